// File: doc/BRIEF.md
# Interrupt Crossbar Routing Register File

This block sits between a set of peripheral interrupt lines and the inputs of a downstream interrupt controller. Each controller-facing output owns a small select register holding a source number, and the output carries the live, active-high level of that source. Software programs the select registers through a plain byte-addressed write/read port. Priority, masking and completion handling stay in the downstream controller. The policy for handing out routes stays with whatever allocates them.

Some outputs can be declared reserved at build time. A reserved output is tied low and is given no register at all, so the addresses of the entries after it close up. Other outputs can be declared bypass. A bypass output is hardwired to one fixed source: it keeps its address slot, but that slot reads back the fixed source number and ignores writes. Every other output comes out of reset pointing at a common safe source number. Software releases a route by writing that safe number back. The entry width of 1, 2 or 4 bytes is chosen at build time and sets both the address stride and the number of stored bits.

Top module: `irq_xbar`

## Requirements
- R1: After reset, every output that is neither reserved nor bypass holds the safe source number SAFE_SEL (default 31), reads it back, and drives the level of that source.
- R2: A write with wr_en high to the address of a programmable entry stores wdata[8*ENTRY_BYTES-1:0] at the next rising clock edge. rdata, which is combinational from addr, returns the stored value zero-extended to 32 bits.
- R3: A routed output equals the current level of src_in at the index held in its select register, active-high, with no register in the path.
- R4: A select value at or above NUM_SRC (default 32) drives the output constantly low, whatever src_in is.
- R5: Entries are compacted. The slot of output k is the number of non-reserved outputs below k, and its byte address is slot*ENTRY_BYTES. With the defaults (output 2 reserved), outputs 0,1,3,4,5,6,7 sit at addresses 0,1,2,3,4,5,6.
- R6: A reserved output (default: output 2) is always low and no address reaches it.
- R7: A bypass output (default: output 5, fixed source 7) follows its fixed source both at reset and afterwards. Its slot (default address 4) reads the fixed source number, and writes to it change nothing.
- R8: An address that maps to no entry is ignored by writes and reads as zero. Such addresses are those past the last slot, and, for entries wider than one byte, those not aligned to the entry size.
- R9: With ENTRY_BYTES=4 a full 32-bit select value is stored and read back. With ENTRY_BYTES=1 only the low 8 bits of wdata are kept.
- R10: Writing SAFE_SEL back into an entry (release) returns that output to the safe source, as after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the entry at addr |
| addr | input | ADDR_W | Byte address of the entry to write or read |
| wdata | input | 32 | Write data; the low 8*ENTRY_BYTES bits are used |
| rdata | output | 32 | Read data for addr, zero-extended entry value |
| src_in | input | NUM_SRC | Peripheral interrupt levels |
| irq_out | output | NUM_OUT | Active-high levels toward the downstream controller |

## Verification
The bench aims at address compaction. A design that left a hole for the reserved output would send the write to address 2 to output 2 rather than output 3, and the route would fail to appear on the expected pin. It writes to the bypass slot and to unmapped and misaligned addresses. A design that decoded these loosely would move a route or return stale data instead of zero. It programs select values beyond the source count and over-wide data in both entry widths. A design that wrapped the index or failed to truncate would raise an output from the wrong source or read back bits it should not hold. Finally, it releases routes to the safe number and checks the reset state, so a design that reset to zero, or loaded the safe number into the bypass output, is caught on the pins.

// File: rtl/irq_xbar.sv
module irq_xbar #(
  parameter int NUM_OUT     = 8,
  parameter int NUM_SRC     = 32,
  parameter int ENTRY_BYTES = 1,
  parameter int ADDR_W      = 8,
  parameter logic [NUM_OUT-1:0]   RSVD_MASK = 8'b0000_0100,
  parameter logic [NUM_OUT-1:0]   BYP_MASK  = 8'b0010_0000,
  parameter logic [NUM_OUT*8-1:0] BYP_SRC   = 64'h0000_0700_0000_0000,
  parameter int SAFE_SEL    = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_OUT-1:0] irq_out
);
  localparam int ENTRY_W = 8 * ENTRY_BYTES;
  localparam int SRC_IW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  function automatic int slot_of(int k);
    int n = 0;
    for (int i = 0; i < k; i++) if (!RSVD_MASK[i]) n++;
    return n;
  endfunction

  function automatic logic pick(logic [NUM_SRC-1:0] s, logic [31:0] v);
    if (v < 32'(NUM_SRC)) return s[v[SRC_IW-1:0]];
    return 1'b0;
  endfunction

  logic [NUM_OUT-1:0] slot_hit;
  logic [31:0]        rd_val [NUM_OUT];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (RSVD_MASK[k]) begin : g_rsvd
      assign slot_hit[k] = 1'b0;
      assign rd_val[k]   = '0;
      assign irq_out[k]  = 1'b0;
    end else if (BYP_MASK[k]) begin : g_byp
      localparam int ADR = slot_of(k) * ENTRY_BYTES;
      localparam logic [7:0] BS = BYP_SRC[k*8 +: 8];
      assign slot_hit[k] = (addr == ADDR_W'(ADR));
      assign rd_val[k]   = 32'(BS);
      assign irq_out[k]  = pick(src_in, 32'(BS));
    end else begin : g_prog
      localparam int ADR = slot_of(k) * ENTRY_BYTES;
      logic [ENTRY_W-1:0] sel_q;
      assign slot_hit[k] = (addr == ADDR_W'(ADR));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   sel_q <= ENTRY_W'(SAFE_SEL);
        else if (wr_en && slot_hit[k]) sel_q <= wdata[ENTRY_W-1:0];
      end
      assign rd_val[k]  = 32'(sel_q);
      assign irq_out[k] = pick(src_in, 32'(sel_q));
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_OUT; k++)
      if (slot_hit[k]) rdata = rdata | rd_val[k];
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/irq_xbar_chk.sv
module irq_xbar_chk #(
  parameter int NUM_OUT     = 8,
  parameter int NUM_SRC     = 32,
  parameter int ENTRY_BYTES = 1,
  parameter int ADDR_W      = 8,
  parameter logic [NUM_OUT-1:0] RSVD_MASK = 8'b0000_0100,
  parameter logic [NUM_OUT-1:0] BYP_MASK  = 8'b0010_0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wdata,
  input logic [31:0]        rdata,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_OUT-1:0] irq_out
);
  localparam int NSLOTS = NUM_OUT - $countones(RSVD_MASK);
  localparam logic [31:0] EMASK =
    (ENTRY_BYTES >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * ENTRY_BYTES)) - 32'd1);

  function automatic logic mapped(logic [ADDR_W-1:0] a);
    int ai = int'(a);
    return (ai % ENTRY_BYTES == 0) && (ai / ENTRY_BYTES < NSLOTS);
  endfunction

  function automatic logic byp_slot(logic [ADDR_W-1:0] a);
    int n = 0;
    logic r = 1'b0;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (!RSVD_MASK[k]) begin
        if (BYP_MASK[k] && int'(a) == n * ENTRY_BYTES) r = 1'b1;
        n++;
      end
    end
    return r;
  endfunction

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mapped(addr) |-> rdata == 32'd0);

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en) && mapped($past(addr)) && !byp_slot($past(addr)) && $stable(addr)
      |-> rdata == ($past(wdata) & EMASK));

  assert_route_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(wr_en) && $stable(src_in) |-> $stable(irq_out));

  assert_bypass_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $stable(src_in) |-> $stable(irq_out & BYP_MASK));
endmodule

bind irq_xbar irq_xbar_chk #(
  .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .ENTRY_BYTES(ENTRY_BYTES),
  .ADDR_W(ADDR_W), .RSVD_MASK(RSVD_MASK), .BYP_MASK(BYP_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .src_in(src_in), .irq_out(irq_out)
);

// File: tb/irq_xbar_test.sv
module irq_xbar_test;
  logic clk = 0, rst_n = 0;
  logic we1 = 0, we4 = 0;
  logic [7:0]  a1 = 0, a4 = 0;
  logic [31:0] d1 = 0, d4 = 0, r1, r4;
  logic [31:0] src = 0;
  logic [7:0]  o1, o4;
  int n_chk = 0, n_fail = 0;
  int m1 [8], m4 [8];

  localparam logic [7:0] RSVD = 8'h04, BYP = 8'h20;

  always #2 clk = ~clk;

  irq_xbar uut (.clk(clk), .rst_n(rst_n), .wr_en(we1), .addr(a1), .wdata(d1),
                .rdata(r1), .src_in(src), .irq_out(o1));
  irq_xbar #(.ENTRY_BYTES(4)) uut_w (.clk(clk), .rst_n(rst_n), .wr_en(we4), .addr(a4),
                .wdata(d4), .rdata(r4), .src_in(src), .irq_out(o4));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int out_of(int a, int eb);
    int n = 0;
    if (a % eb != 0) return -1;
    for (int k = 0; k < 8; k++)
      if (!RSVD[k]) begin
        if (n == a / eb) return k;
        n++;
      end
    return -1;
  endfunction

  function automatic logic [7:0] exp_out(input int m [8], logic [31:0] s);
    logic [7:0] e = 0;
    for (int k = 0; k < 8; k++) begin
      if (RSVD[k])      e[k] = 1'b0;
      else if (BYP[k])  e[k] = s[7];
      else if (m[k] >= 0 && m[k] < 32) e[k] = s[m[k]];
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(input int m [8], int a, int eb);
    int k = out_of(a, eb);
    if (k < 0) return 0;
    if (BYP[k]) return 7;
    return 32'(m[k]);
  endfunction

  task automatic wr1(int a, logic [31:0] d);
    int k = out_of(a, 1);
    @(negedge clk); we1 = 1; a1 = 8'(a); d1 = d;
    @(negedge clk); we1 = 0;
    if (k >= 0 && !BYP[k]) m1[k] = int'(d & 32'hFF);
  endtask

  task automatic wr4(int a, logic [31:0] d);
    int k = out_of(a, 4);
    @(negedge clk); we4 = 1; a4 = 8'(a); d4 = d;
    @(negedge clk); we4 = 0;
    if (k >= 0 && !BYP[k]) m4[k] = int'(d);
  endtask

  task automatic rd1(string req, int a);
    @(negedge clk); a1 = 8'(a); #1;
    check(req, r1, exp_rd(m1, a, 1));
  endtask

  task automatic rd4(string req, int a);
    @(negedge clk); a4 = 8'(a); #1;
    check(req, r4, exp_rd(m4, a, 4));
  endtask

  task automatic routes(string req, logic [31:0] s);
    @(negedge clk); src = s; #1;
    check(req, 32'(o1), 32'(exp_out(m1, s)));
    check(req, 32'(o4), 32'(exp_out(m4, s)));
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd1("R1 reset read", a);
    for (int a = 0; a < 32; a += 4) rd4("R1 reset read wide", a);
    check("R1 safe route", 32'(o1), 32'h0);
    routes("R1 safe route", 32'h8000_0000);
    check("R1 safe route pins", 32'(o1), 32'hDB);
    routes("R7 bypass at reset", 32'h0000_0080);
    check("R7 bypass pin", 32'(o1), 32'h20);
  endtask

  task automatic t_compact;
    wr1(2, 9);
    routes("R5 addr2 to out3", 32'h0000_0200);
    check("R5 out3 only", 32'(o1), 32'h08);
    wr1(0, 0); wr1(1, 1); wr1(3, 12); wr1(5, 20); wr1(6, 30);
    for (int a = 0; a < 8; a++) rd1("R5 readback", a);
    routes("R3 pattern a", 32'hA5A5_5A5A);
    routes("R3 pattern b", 32'h4010_1203);
    routes("R3 pattern c", 32'hFFFF_FFFF);
    routes("R3 pattern d", 32'h0000_0000);
  endtask

  task automatic t_high;
    wr1(6, 40);
    rd1("R4 high sel read", 6);
    routes("R4 high sel low", 32'hFFFF_FFFF);
    check("R4 out7 low", 32'(o1[7]), 32'h0);
    wr1(6, 32);
    routes("R4 sel equal count", 32'hFFFF_FFFF);
  endtask

  task automatic t_bypass;
    wr1(4, 3);
    rd1("R7 bypass read fixed", 4);
    routes("R7 bypass follows 7", 32'h0000_0008);
    check("R7 bypass ignores write", 32'(o1[5]), 32'h0);
    routes("R7 bypass src7", 32'h0000_0080);
    check("R7 bypass src7 pin", 32'(o1[5]), 32'h1);
    wr4(16, 2);
    rd4("R7 bypass wide read", 16);
  endtask

  task automatic t_unmapped;
    wr1(7, 0); wr1(200, 0); wr1(255, 5);
    rd1("R8 beyond last", 7);
    rd1("R8 far addr", 200);
    for (int a = 0; a < 7; a++) rd1("R8 entries unchanged", a);
    wr4(9, 0); wr4(30, 0); wr4(28, 1);
    rd4("R8 misaligned read", 9);
    rd4("R8 beyond wide", 28);
    for (int a = 0; a < 28; a += 4) rd4("R8 wide unchanged", a);
    routes("R8 routes unchanged", 32'hFFFF_FFFF);
  endtask

  task automatic t_width;
    wr1(0, 32'h0000_0105);
    rd1("R9 narrow truncates", 0);
    check("R9 narrow value", r1, 32'h05);
    wr4(8, 32'h0000_0105);
    rd4("R9 wide keeps", 8);
    check("R9 wide value", r4, 32'h105);
    routes("R9 wide high sel low", 32'hFFFF_FFFF);
    check("R9 wide out3 low", 32'(o4[3]), 32'h0);
    wr4(0, 32'hDEAD_BEEF);
    rd4("R9 full word", 0);
  endtask

  task automatic t_release;
    for (int a = 0; a < 7; a++) if (a != 4) wr1(a, 31);
    for (int a = 0; a < 28; a += 4) if (a != 16) wr4(a, 31);
    for (int a = 0; a < 7; a++) rd1("R10 released read", a);
    routes("R10 released route", 32'h8000_0000);
    check("R10 safe pins", 32'(o1), 32'hDB);
    check("R10 safe pins wide", 32'(o4), 32'hDB);
    routes("R6 reserved low", 32'hFFFF_FFFF);
    check("R6 out2 low", 32'(o1[2]), 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      m1[k] = RSVD[k] ? -1 : 31;
      m4[k] = RSVD[k] ? -1 : 31;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_compact;
    t_high;
    t_bypass;
    t_unmapped;
    t_width;
    t_release;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule